// File: doc/BRIEF.md
# Video Memory Bulk Copy and Fill Engine

This block moves or sets runs of bytes in a local video memory on behalf of a register-programmed host. The host loads a 16-bit destination pointer, a 16-bit source pointer, a length and a mode flag through a narrow byte-wide configuration port. A write to the data register then launches the transfer with no further command.

In fill mode the data byte is stored at consecutive destination addresses. In copy mode each byte is first read from the source pointer and then written to the destination pointer. The length register holds the number of bytes minus one. Both pointers advance as the work proceeds, and they keep their advanced values afterwards, so back-to-back transfers continue where the last one stopped.

Memory is reached through a single-port request/grant handshake. The engine raises `busy` for the whole transfer and ignores configuration writes while it is high.

Top module: `vmem_bulk_engine`

## Requirements
- R1: After reset, `busy` and `mem_req` are 0, and both pointers and the data byte read 0.
- R2: A configuration write with `cfg_sel` 0/1 loads the high/low byte of the destination pointer. Select 2/3 does the same for the source pointer, 4 loads the length (bytes minus one), 5 loads the mode (bit 0: 0 = fill, 1 = copy), and 6 writes the data byte and starts a transfer.
- R3: In fill mode, a data write stores that byte at length+1 consecutive addresses starting at the destination pointer, with no memory reads.
- R4: In copy mode, length+1 bytes are moved. Each byte takes one read at the source pointer followed by one write at the destination pointer, and both pointers step by one per byte.
- R5: Both pointers wrap from 0xFFFF to 0x0000.
- R6: `busy` is high from the cycle after the starting data write until the grant of the final memory write. It is low in the following cycle.
- R7: While `busy` is high, every configuration write (pointers, length, mode, data) has no effect.
- R8: After a transfer, the destination pointer is one past the last byte written, and the data byte output shows the last byte written. The source pointer is one past the last byte read in copy mode and is unchanged by a fill.
- R9: A memory request keeps its address, direction and write data unchanged until it is granted.
- R10: A length of 0 performs exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Configuration write byte |
| busy | output | 1 | Transfer in progress |
| upd_addr | output | 16 | Destination pointer |
| src_addr | output | 16 | Source pointer |
| data_byte | output | 8 | Current data byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read data, valid in the grant cycle of a read |

## Verification
The assertions assume the memory side follows the handshake: a grant arrives only while a request is raised, and read data is valid in the same cycle as the grant of a read. The behavioural memory in the bench derives its grant from `mem_req` and a programmable wait counter, so it never grants when no request is raised. It returns read data combinationally from the requested address. The grant delay is varied between tests, which exercises the hold rule with both zero-wait and multi-cycle stalls.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
  typedef enum logic [2:0] {
    SEL_UPD_HI = 3'd0,
    SEL_UPD_LO = 3'd1,
    SEL_SRC_HI = 3'd2,
    SEL_SRC_LO = 3'd3,
    SEL_COUNT  = 3'd4,
    SEL_MODE   = 3'd5,
    SEL_DATA   = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/vbe_addr_reg.sv
module vbe_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [7:0]        byte_in,
  input  logic              step,
  output logic [ADDR_W-1:0] q
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_d = q;
    if (ld_hi) q_d[ADDR_W-1:8] = byte_in[HI_W-1:0];
    if (ld_lo) q_d[7:0]        = byte_in;
    if (step)  q_d             = q + 1'b1;
  end

  assign q_en = ld_hi | ld_lo | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/vbe_engine_ctrl.sv
module vbe_engine_ctrl
  import vbe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              copy_mode,
  input  logic [CNT_W-1:0]  count,
  input  logic [7:0]        start_byte,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              step_upd,
  output logic              step_src,
  output logic [7:0]        data_q
);
  eng_state_e       st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [7:0]       data_d;
  logic             work_en;

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    data_d   = data_q;
    step_upd = 1'b0;
    step_src = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          data_d = start_byte;
          rem_d  = count;
          st_d   = copy_mode ? ST_READ : ST_WRITE;
        end
      end
      ST_READ: begin
        if (mem_gnt) begin
          data_d   = mem_rdata;
          step_src = 1'b1;
          st_d     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_gnt) begin
          step_upd = 1'b1;
          if (rem_q == '0) begin
            st_d = ST_IDLE;
          end else begin
            rem_d = rem_q - 1'b1;
            st_d  = copy_mode ? ST_READ : ST_WRITE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign work_en = (st_q == ST_IDLE) ? start : mem_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      data_q <= '0;
    end else if (work_en) begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      data_q <= data_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st_q == ST_WRITE);
  assign mem_addr  = mem_we ? upd_addr : src_addr;
  assign mem_wdata = data_q;

  // R9: a stalled request must not change until granted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata)))
    else $error("request changed before grant");

  // R4: a granted read is always followed by a write of the fetched byte
  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_gnt) |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata)))
    else $error("copy read not followed by write");
endmodule

// File: rtl/vmem_bulk_engine.sv
module vmem_bulk_engine
  import vbe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [ADDR_W-1:0] src_addr,
  output logic [7:0]        data_byte,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata
);
  localparam int NPTR = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  reg_sel_e         sel_e;
  logic             accept, start;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;
  logic             cnt_en, mode_en;
  logic [NPTR-1:0]  ld_hi, ld_lo, step;
  logic [ADDR_W-1:0] ptr_q [NPTR];
  logic             step_upd, step_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign sel_e  = reg_sel_e'(cfg_sel);
  assign accept = cfg_we && !busy;
  assign start  = accept && (sel_e == SEL_DATA);

  always_comb begin
    cnt_d   = cfg_wdata[CNT_W-1:0];
    mode_d  = cfg_wdata[0];
    cnt_en  = accept && (sel_e == SEL_COUNT);
    mode_en = accept && (sel_e == SEL_MODE);
    ld_hi   = {accept && (sel_e == SEL_SRC_HI), accept && (sel_e == SEL_UPD_HI)};
    ld_lo   = {accept && (sel_e == SEL_SRC_LO), accept && (sel_e == SEL_UPD_LO)};
    step    = {step_src, step_upd};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  // index 0: destination pointer, index 1: source pointer
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    vbe_addr_reg #(.ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .ld_hi   (ld_hi[g]),
      .ld_lo   (ld_lo[g]),
      .byte_in (cfg_wdata),
      .step    (step[g]),
      .q       (ptr_q[g])
    );
  end

  assign upd_addr = ptr_q[0];
  assign src_addr = ptr_q[1];

  vbe_engine_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .copy_mode  (mode_q),
    .count      (cnt_q),
    .start_byte (cfg_wdata),
    .upd_addr   (upd_addr),
    .src_addr   (src_addr),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .step_upd   (step_upd),
    .step_src   (step_src),
    .data_q     (data_byte)
  );

  // R6: a data write while idle starts a transfer on the next cycle
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_we && cfg_sel == 3'd6 && !busy) |=> busy)
    else $error("data write did not start transfer");

  // R6: no memory traffic while idle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !mem_req)
    else $error("request while idle");

  // R5: destination advances by one (mod 2^ADDR_W) after each granted write
  p_dst_step_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && mem_we && mem_gnt) |=> (upd_addr == ADDR_W'($past(mem_addr) + 1'b1)))
    else $error("destination pointer did not step");

  // R4: source advances by one after each granted read
  p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_we && mem_gnt) |=> (src_addr == ADDR_W'($past(mem_addr) + 1'b1)))
    else $error("source pointer did not step");

  // R3: a fill never reads memory
  p_fill_no_read_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !mode_q) |-> !(mem_req && !mem_we))
    else $error("read issued in fill mode");

  // R7: length and mode are frozen during a transfer
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> ($stable(cnt_q) && $stable(mode_q)))
    else $error("configuration changed while busy");
endmodule

// File: tb/vmem_bulk_engine_bench.sv
module vmem_bulk_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        busy;
  logic [15:0] upd_addr, src_addr, mem_addr;
  logic [7:0]  data_byte, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_gnt;

  int n_tests = 0;
  int n_fail  = 0;
  int gnt_delay = 0;
  int wait_cnt  = 0;
  int rd_cnt = 0, wr_cnt = 0, hold_err = 0;
  logic        pend = 1'b0;
  logic [15:0] p_addr;
  logic        p_we;
  logic [7:0]  p_wd;
  logic [7:0]  mem   [256];
  logic [7:0]  model [256];

  always #5 clk = ~clk;

  vmem_bulk_engine u_vmem_bulk_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .upd_addr(upd_addr), .src_addr(src_addr), .data_byte(data_byte),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_byte(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  assign mem_gnt   = mem_req && (wait_cnt >= gnt_delay);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed_byte(i);
    end else if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
    if (mem_req && mem_gnt) begin
      if (mem_we) wr_cnt <= wr_cnt + 1;
      else        rd_cnt <= rd_cnt + 1;
    end
    if (!mem_req || mem_gnt) wait_cnt <= 0;
    else                     wait_cnt <= wait_cnt + 1;
    if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
      hold_err <= hold_err + 1;
    pend   <= mem_req && !mem_gnt;
    p_addr <= mem_addr;
    p_we   <= mem_we;
    p_wd   <= mem_wdata;
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] sel, logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ptrs(logic [15:0] dst, logic [15:0] src);
    reg_write(3'd0, dst[15:8]); reg_write(3'd1, dst[7:0]);
    reg_write(3'd2, src[15:8]); reg_write(3'd3, src[7:0]);
  endtask

  task automatic wait_idle(string req);
    int cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
    check(req, int'(busy), 0);
  endtask

  task automatic compare_mem(string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) bad++;
    check(req, bad, 0);
  endtask

  task automatic model_run(logic [15:0] dst, logic [15:0] src, int cnt, bit copy, logic [7:0] d);
    for (int i = 0; i <= cnt; i++) begin
      if (copy) model[8'(dst + i)] = model[8'(src + i)];
      else      model[8'(dst + i)] = d;
    end
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 req", int'(mem_req), 0);
    check("R1 upd", int'(upd_addr), 0);
    check("R1 src", int'(src_addr), 0);
    check("R1 data", int'(data_byte), 0);
  endtask

  task automatic t_load();
    set_ptrs(16'h1234, 16'hABCD);
    check("R2 upd load", int'(upd_addr), 16'h1234);
    check("R2 src load", int'(src_addr), 16'hABCD);
  endtask

  task automatic t_fill();
    int w0;
    gnt_delay = 0;
    set_ptrs(16'h0010, 16'h0700);
    reg_write(3'd4, 8'd4); reg_write(3'd5, 8'h00);
    w0 = wr_cnt;
    reg_write(3'd6, 8'h5A);
    check("R6 busy after start", int'(busy), 1);
    model_run(16'h0010, 16'h0700, 4, 1'b0, 8'h5A);
    wait_idle("R6 idle after fill");
    check("R3 fill writes", wr_cnt - w0, 5);
    compare_mem("R3 fill memory");
    check("R8 fill upd", int'(upd_addr), 16'h0015);
    check("R8 fill src unchanged", int'(src_addr), 16'h0700);
    check("R8 fill data", int'(data_byte), 8'h5A);
  endtask

  task automatic t_copy();
    int w0, r0;
    gnt_delay = 1;
    set_ptrs(16'h0080, 16'h0040);
    reg_write(3'd4, 8'd7); reg_write(3'd5, 8'h01);
    w0 = wr_cnt; r0 = rd_cnt;
    reg_write(3'd6, 8'hEE);
    model_run(16'h0080, 16'h0040, 7, 1'b1, 8'h00);
    wait_idle("R6 idle after copy");
    check("R4 copy reads", rd_cnt - r0, 8);
    check("R4 copy writes", wr_cnt - w0, 8);
    compare_mem("R4 copy memory");
    check("R8 copy upd", int'(upd_addr), 16'h0088);
    check("R8 copy src", int'(src_addr), 16'h0048);
    check("R8 copy data", int'(data_byte), int'(model[8'h87]));
  endtask

  task automatic t_wrap();
    gnt_delay = 2;
    set_ptrs(16'hFFFE, 16'hFFFF);
    reg_write(3'd4, 8'd3); reg_write(3'd5, 8'h01);
    reg_write(3'd6, 8'h00);
    model_run(16'hFFFE, 16'hFFFF, 3, 1'b1, 8'h00);
    wait_idle("R5 idle after wrap");
    compare_mem("R5 wrap memory");
    check("R5 upd wrap", int'(upd_addr), 16'h0002);
    check("R5 src wrap", int'(src_addr), 16'h0003);
  endtask

  task automatic t_single();
    int w0;
    gnt_delay = 0;
    set_ptrs(16'h00C0, 16'h0000);
    reg_write(3'd4, 8'd0); reg_write(3'd5, 8'h00);
    w0 = wr_cnt;
    reg_write(3'd6, 8'h77);
    model_run(16'h00C0, 16'h0000, 0, 1'b0, 8'h77);
    wait_idle("R10 idle");
    check("R10 single write", wr_cnt - w0, 1);
    check("R10 upd", int'(upd_addr), 16'h00C1);
    compare_mem("R10 memory");
  endtask

  task automatic t_ignore();
    gnt_delay = 2;
    set_ptrs(16'h0060, 16'h0000);
    reg_write(3'd4, 8'd20); reg_write(3'd5, 8'h00);
    reg_write(3'd6, 8'hC3);
    model_run(16'h0060, 16'h0000, 20, 1'b0, 8'hC3);
    reg_write(3'd0, 8'h12); reg_write(3'd1, 8'h34);
    reg_write(3'd2, 8'h56); reg_write(3'd3, 8'h78);
    reg_write(3'd4, 8'd1);  reg_write(3'd5, 8'h01);
    reg_write(3'd6, 8'h11);
    check("R7 still busy", int'(busy), 1);
    wait_idle("R7 idle");
    check("R7 upd unaffected", int'(upd_addr), 16'h0075);
    check("R7 src unaffected", int'(src_addr), 16'h0000);
    check("R7 data unaffected", int'(data_byte), 8'hC3);
    compare_mem("R7 memory");
    reg_write(3'd6, 8'h22);
    model_run(16'h0075, 16'h0000, 20, 1'b0, 8'h22);
    wait_idle("R7 idle 2");
    check("R7 length and mode kept", int'(upd_addr), 16'h008A);
    compare_mem("R7 memory 2");
    check("R9 request hold", hold_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = seed_byte(i);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 3'd7; cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_fill();
    t_copy();
    t_wrap();
    t_single();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule